// File: doc/BRIEF.md
# PHY Management Register Block with One-Shot Write Unlock

This block sits on the PHY side of a station-management link. An MDIO frame decoder outside the block turns serial transactions into a plain register strobe: a write pulse with an address and 16 bits of data, plus an address for combinational read-back. The block holds three registers:

- a control register whose top bit requests a software reset;
- an extended control register;
- a register whose upper bits are protected.

The extended control register carries a self-clearing unlock flag, the 5-bit station address, a test bit and a line-coding select bit. The station address is read-only and is taken from strap pins during a hardware reset.

Protected bits can be changed only by the single write that follows arming the unlock flag. The write that arms the flag does not use it up. The next write of any kind clears it, so a second write after one unlock finds the bits locked again. Software reset returns every writable field to its default and drops the unlock. It leaves the strapped station address as it was.

The coding-select bit goes to the transmit path as a level. It chooses NRZ or NRZI encoding at 100 Mb/s. The test bit also goes out as a level, and it forces the receive descrambler to lose lock and resynchronise.

Top module: `mgmt_xctl_regs`

## Requirements
- R1: While rst_n is low, the station address is loaded from strap_addr_i. After reset, register 16 reads with the strap at bits 10:6, bit 3 (coding) = 1, bit 5 (test) = 0 and bit 15 (unlock) = 0. Register 17 reads 0x0000, nrzi_sel_o = 1 and descr_drop_o = 0.
- R2: A write to register 16 with bit 15 = 1 arms the unlock, and register 16 then reads bit 15 as 1. The arming write changes no protected bit.
- R3: While the unlock is armed, the next write to any register disarms it, unless that write is itself another arming write. If that write targets register 17, bits 15:8 take the written value.
- R4: A write to register 17 without the unlock armed leaves bits 15:8 unchanged and writes bits 7:0.
- R5: After one arming, a second write to register 17 finds bits 15:8 locked again.
- R6: Bits 10:6 of register 16 ignore writes. They keep their value through a software reset and through any strap change that happens outside hardware reset.
- R7: Bit 3 of register 16 can be written and drives nrzi_sel_o (1 = NRZI, 0 = NRZ) from the cycle after the write.
- R8: Bit 5 of register 16 can be written and drives descr_drop_o (1 = force descrambler lock loss) from the cycle after the write.
- R9: Bits 14:11, 4 and 2:0 of register 16 always read 0, and writes to them have no effect.
- R10: A write to register 0 with bit 15 = 1 is a software reset. It restores bits 3 and 5 of register 16 and all of register 17 to their reset values and clears the unlock. Register 0 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous; also latches the straps |
| strap_addr_i | input | 5 | Station address strap pins |
| reg_wr_i | input | 1 | One-cycle register write strobe |
| reg_addr_i | input | 5 | Register address for write and read-back |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Combinational read data for reg_addr_i |
| nrzi_sel_o | output | 1 | Transmit line coding select, 1 = NRZI |
| descr_drop_o | output | 1 | Forces the receive descrambler to lose lock |

## Verification
The state that is hardest to reach from the ports is an unlock that is armed and then used up by a write that does not touch the protected register. Nothing is left on the protected register to show it, so only a later locked write shows whether the flag was truly spent. The vector walk reaches it by arming, consuming the flag with a plain write to register 16, and then writing all ones to register 17. It also reads register 16 between steps so the flag is seen directly. A software reset issued while the flag is armed, followed by a write to register 17, confirms that the reset drops a pending unlock.

// File: rtl/mgmt_xctl_pkg.sv
package mgmt_xctl_pkg;
   // bit positions that the management software decodes
   localparam int unsigned XC_UNLOCK  = 15;
   localparam int unsigned XC_SA_HI   = 10;
   localparam int unsigned XC_SA_LO   = 6;
   localparam int unsigned XC_SCRT    = 5;
   localparam int unsigned XC_CODE    = 3;
   localparam int unsigned CT_SWRST   = 15;
   // reserved bits of the extended control register
   localparam logic [15:0] XC_RSVD_MASK = 16'h7817;
endpackage

// File: rtl/mgmt_unlock_ctrl.sv
module mgmt_unlock_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic sw_rst,
   input  logic wr_en,
   input  logic arm_req,
   output logic armed
);
   // any write spends the unlock, unless the write re-arms it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         armed <= 1'b0;
      else if (sw_rst)
         armed <= 1'b0;
      else if (wr_en)
         armed <= arm_req;
   end
endmodule

// File: rtl/mgmt_strap_latch.sv
module mgmt_strap_latch #(
   parameter int unsigned SA_W = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [SA_W-1:0] strap,
   output logic [SA_W-1:0] st_addr
);
   // tracks the straps only while hardware reset is held
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         st_addr <= strap;
      else
         st_addr <= st_addr;
   end
endmodule

// File: rtl/mgmt_prot_reg.sv
module mgmt_prot_reg #(
   parameter int unsigned   DW       = 16,
   parameter logic [DW-1:0] MASK     = '0,
   parameter logic [DW-1:0] RST_VAL  = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sw_rst,
   input  logic          wr_en,
   input  logic          armed,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] q
);
   for (genvar b = 0; b < DW; b++) begin : g_bit
      if (MASK[b]) begin : g_guarded
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                q[b] <= RST_VAL[b];
            else if (sw_rst)           q[b] <= RST_VAL[b];
            else if (wr_en && armed)   q[b] <= wdata[b];
         end
      end else begin : g_open
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                q[b] <= RST_VAL[b];
            else if (sw_rst)           q[b] <= RST_VAL[b];
            else if (wr_en)            q[b] <= wdata[b];
         end
      end
   end
endmodule

// File: rtl/mgmt_xctl_regs.sv
module mgmt_xctl_regs #(
   parameter int unsigned   DW        = 16,
   parameter int unsigned   AW        = 5,
   parameter int unsigned   SA_W      = 5,
   parameter int unsigned   CTRL_REG  = 0,
   parameter int unsigned   XCTL_REG  = 16,
   parameter int unsigned   PROT_REG  = 17,
   parameter logic [DW-1:0] PROT_MASK = 16'hFF00,
   parameter logic [DW-1:0] PROT_RST  = 16'h0000,
   parameter logic          CODE_RST  = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [SA_W-1:0] strap_addr_i,
   input  logic            reg_wr_i,
   input  logic [AW-1:0]   reg_addr_i,
   input  logic [DW-1:0]   reg_wdata_i,
   output logic [DW-1:0]   reg_rdata_o,
   output logic            nrzi_sel_o,
   output logic            descr_drop_o
);
   import mgmt_xctl_pkg::*;

   localparam logic [AW-1:0] A_CTRL = AW'(CTRL_REG);
   localparam logic [AW-1:0] A_XCTL = AW'(XCTL_REG);
   localparam logic [AW-1:0] A_PROT = AW'(PROT_REG);

   // elaboration checks
   if (DW != 16) begin : g_bad_dw
      $error("mgmt_xctl_regs: field layout needs DW == 16");
   end
   if (SA_W != XC_SA_HI - XC_SA_LO + 1) begin : g_bad_sa
      $error("mgmt_xctl_regs: station address must fill bits 10:6");
   end
   if (CTRL_REG >= (1 << AW) || XCTL_REG >= (1 << AW) || PROT_REG >= (1 << AW)) begin : g_bad_aw
      $error("mgmt_xctl_regs: register index exceeds address width");
   end
   if (CTRL_REG == XCTL_REG || CTRL_REG == PROT_REG || XCTL_REG == PROT_REG) begin : g_bad_map
      $error("mgmt_xctl_regs: register indices must differ");
   end

   logic            wr_ctrl, wr_xctl, wr_prot;
   logic            sw_rst, arm_req, armed_q;
   logic [SA_W-1:0] st_addr;
   logic [DW-1:0]   prot_q;
   logic            scrt_q, code_q;

   assign wr_ctrl = reg_wr_i && (reg_addr_i == A_CTRL);
   assign wr_xctl = reg_wr_i && (reg_addr_i == A_XCTL);
   assign wr_prot = reg_wr_i && (reg_addr_i == A_PROT);
   assign sw_rst  = wr_ctrl && reg_wdata_i[CT_SWRST];
   assign arm_req = wr_xctl && reg_wdata_i[XC_UNLOCK];

   mgmt_unlock_ctrl u_unlock (
      .clk     (clk),
      .rst_n   (rst_n),
      .sw_rst  (sw_rst),
      .wr_en   (reg_wr_i),
      .arm_req (arm_req),
      .armed   (armed_q)
   );

   mgmt_strap_latch #(.SA_W(SA_W)) u_strap (
      .clk     (clk),
      .rst_n   (rst_n),
      .strap   (strap_addr_i),
      .st_addr (st_addr)
   );

   mgmt_prot_reg #(.DW(DW), .MASK(PROT_MASK), .RST_VAL(PROT_RST)) u_prot (
      .clk    (clk),
      .rst_n  (rst_n),
      .sw_rst (sw_rst),
      .wr_en  (wr_prot),
      .armed  (armed_q),
      .wdata  (reg_wdata_i),
      .q      (prot_q)
   );

   // writable fields of the extended control register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scrt_q <= 1'b0;
         code_q <= CODE_RST;
      end else if (sw_rst) begin
         scrt_q <= 1'b0;
         code_q <= CODE_RST;
      end else if (wr_xctl) begin
         scrt_q <= reg_wdata_i[XC_SCRT];
         code_q <= reg_wdata_i[XC_CODE];
      end
   end

   logic [DW-1:0] xctl_view;
   always_comb begin
      xctl_view                    = '0;
      xctl_view[XC_UNLOCK]         = armed_q;
      xctl_view[XC_SA_HI:XC_SA_LO] = st_addr;
      xctl_view[XC_SCRT]           = scrt_q;
      xctl_view[XC_CODE]           = code_q;
   end

   always_comb begin
      if (reg_addr_i == A_XCTL)      reg_rdata_o = xctl_view;
      else if (reg_addr_i == A_PROT) reg_rdata_o = prot_q;
      else                           reg_rdata_o = '0;
   end

   assign nrzi_sel_o   = code_q;
   assign descr_drop_o = scrt_q;
endmodule

// File: rtl/mgmt_xctl_regs_chk.sv
module mgmt_xctl_regs_chk #(
   parameter int unsigned   DW        = 16,
   parameter int unsigned   AW        = 5,
   parameter int unsigned   SA_W      = 5,
   parameter int unsigned   XCTL_REG  = 16,
   parameter int unsigned   PROT_REG  = 17,
   parameter logic [DW-1:0] PROT_MASK = 16'hFF00
) (
   input logic            clk,
   input logic            rst_n,
   input logic            reg_wr_i,
   input logic [AW-1:0]   reg_addr_i,
   input logic [DW-1:0]   reg_wdata_i,
   input logic [DW-1:0]   reg_rdata_o,
   input logic            nrzi_sel_o,
   input logic            armed_q,
   input logic [SA_W-1:0] st_addr,
   input logic [DW-1:0]   prot_q
);
   localparam logic [AW-1:0] A_XCTL = AW'(XCTL_REG);
   localparam logic [AW-1:0] A_PROT = AW'(PROT_REG);

   logic            live_q;
   logic [SA_W-1:0] sa_prev;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q  <= 1'b0;
         sa_prev <= '0;
      end else begin
         live_q  <= 1'b1;
         sa_prev <= st_addr;
      end
   end

   // R3: a non-arming write spends the unlock
   a_r3_unlock_spent: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && reg_wr_i && !(reg_addr_i == A_XCTL && reg_wdata_i[15])) |=> !armed_q);

   // R4: guarded bits hold on a locked write
   a_r4_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && reg_addr_i == A_PROT && !armed_q)
      |=> ((prot_q & PROT_MASK) == ($past(prot_q) & PROT_MASK)));

   // R6: the station address never moves outside hardware reset
   a_r6_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      live_q |-> (st_addr == sa_prev));

   // R7: coding output matches its readback bit
   a_r7_code_view: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr_i == A_XCTL) |-> (reg_rdata_o[3] == nrzi_sel_o));

   // R9: reserved bits read zero
   a_r9_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr_i == A_XCTL) |-> ((reg_rdata_o & 16'h7817) == 16'h0000));
endmodule

bind mgmt_xctl_regs mgmt_xctl_regs_chk #(
   .DW(DW), .AW(AW), .SA_W(SA_W), .XCTL_REG(XCTL_REG),
   .PROT_REG(PROT_REG), .PROT_MASK(PROT_MASK)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_wr_i    (reg_wr_i),
   .reg_addr_i  (reg_addr_i),
   .reg_wdata_i (reg_wdata_i),
   .reg_rdata_o (reg_rdata_o),
   .nrzi_sel_o  (nrzi_sel_o),
   .armed_q     (armed_q),
   .st_addr     (st_addr),
   .prot_q      (prot_q)
);

// File: tb/mgmt_xctl_regs_tb_top.sv
module mgmt_xctl_regs_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  strap = 5'd22;
   logic        wr = 1'b0;
   logic [4:0]  addr = 5'd0;
   logic [15:0] wdata = 16'h0;
   logic [15:0] rdata;
   logic        nrzi, drop;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mgmt_xctl_regs dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .strap_addr_i (strap),
      .reg_wr_i     (wr),
      .reg_addr_i   (addr),
      .reg_wdata_i  (wdata),
      .reg_rdata_o  (rdata),
      .nrzi_sel_o   (nrzi),
      .descr_drop_o (drop)
   );

   // vector table: write strobe, write address, write data, readback address,
   // expected readback, expected coding output, expected drop output, requirement
   localparam logic        V_WR [NV] = '{1,1,1,0,1,1,1,1,1,1,1,1,0,0};
   localparam logic [4:0]  V_WA [NV] = '{17,16,17,0,17,16,16,17,16,16,16,0,0,0};
   localparam logic [15:0] V_WD [NV] = '{16'hABCD, 16'h8008, 16'h1234, 16'h0000,
                                         16'h5678, 16'h8008, 16'h0008, 16'hFFFF,
                                         16'h7FF7, 16'h0008, 16'h8000, 16'h8000,
                                         16'h0000, 16'h0000};
   localparam logic [4:0]  V_RA [NV] = '{17,16,17,16,17,16,16,17,16,16,16,16,17,0};
   localparam logic [15:0] V_EX [NV] = '{16'h00CD, // R4 locked write
                                         16'h8588, // R2 armed
                                         16'h1234, // R3 unlocked write
                                         16'h0588, // R3 disarmed
                                         16'h1278, // R5 second write locked
                                         16'h8588, // R2 re-armed
                                         16'h0588, // R3 spent by a reg16 write
                                         16'h12FF, // R5 still locked
                                         16'h05A0, // R6 R7 R8 R9
                                         16'h0588, // R7 R8 back
                                         16'h8580, // R2 R7 arm with NRZ
                                         16'h0588, // R10 R6 soft reset
                                         16'h0000, // R10 reg17 default
                                         16'h0000};// R10 reg0 reads zero
   localparam logic        V_NZ [NV] = '{1,1,1,1,1,1,1,1,0,1,0,1,1,1};
   localparam logic        V_DR [NV] = '{0,0,0,0,0,0,0,0,1,0,0,0,0,0};
   localparam int          V_RQ [NV] = '{4,2,3,3,5,2,3,5,9,7,2,10,10,10};

   task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic check1(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   // write at one negedge, read back at the next (one register on the way)
   task automatic step(input logic w, input logic [4:0] wa, input logic [15:0] wd,
                       input logic [4:0] ra);
      @(negedge clk);
      wr = w; addr = wa; wdata = wd;
      @(negedge clk);
      wr = 1'b0; addr = ra; wdata = 16'h0;
      #1;
   endtask

   task automatic peek(input logic [4:0] ra);
      @(negedge clk);
      addr = ra;
      #1;
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 20000);
      bad++;
      total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      peek(5'd16);
      check16("R1 reg16", rdata, 16'h0588);
      check1("R1 nrzi", nrzi, 1'b1);
      check1("R1 drop", drop, 1'b0);
      peek(5'd17);
      check16("R1 reg17", rdata, 16'h0000);

      for (int i = 0; i < NV; i++) begin
         step(V_WR[i], V_WA[i], V_WD[i], V_RA[i]);
         check16($sformatf("R%0d vec%0d rdata", V_RQ[i], i), rdata, V_EX[i]);
         check1($sformatf("R%0d vec%0d nrzi", V_RQ[i], i), nrzi, V_NZ[i]);
         check1($sformatf("R%0d vec%0d drop", V_RQ[i], i), drop, V_DR[i]);
      end

      // R10 soft reset drops a pending unlock
      step(1'b1, 5'd16, 16'h8008, 5'd16);
      check16("R2 armed before soft reset", rdata, 16'h8588);
      step(1'b1, 5'd0, 16'h8000, 5'd16);
      check16("R10 unlock cleared", rdata, 16'h0588);
      step(1'b1, 5'd17, 16'hAAAA, 5'd17);
      check16("R10 locked after soft reset", rdata, 16'h00AA);

      // R6 strap change outside hardware reset and soft reset keep the address
      strap = 5'd9;
      step(1'b1, 5'd0, 16'h8000, 5'd16);
      check16("R6 address kept", rdata, 16'h0588);

      // R1 hardware reset picks up the new straps
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      peek(5'd16);
      check16("R1 new strap", rdata, 16'h0248);
      peek(5'd17);
      check16("R1 reg17 after hw reset", rdata, 16'h0000);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule